// File: doc/BRIEF.md
# CPU Clock Source and Power-State Controller

This block makes the control decisions for the clock that feeds a processor core. It records which of six run modes is active and which power state the core is in. Each run mode pairs a clock source (main oscillator, PLL, sub oscillator or on-chip oscillator) with a set of oscillators kept running. The block steps through the states that connect those modes and refuses any move that breaks the switching rules. The oscillators themselves, the glitch-free clock multiplexer and PLL locking are outside it. It only drives the source select, the oscillator enables and a CPU clock enable, and it reads one ready flag per oscillator.

Software-style writes ask for a new run mode or load the 5-bit main-clock divider code. Main-clock mode is the hub: a core running from any other source can only go back to main, or move to the partner mode that keeps the same source. A move from either on-chip oscillator mode back to main is only accepted while the divider code is 01000b (divide-by-8). A WAIT strobe parks the core with its clocks still running. A stop request shuts every oscillator down. An interrupt ends either one. After a stop, the block re-enables the current mode's oscillators and waits for them to report ready before it restarts the CPU clock.

The controller has five states:
- RUN: steady operation.
- SWITCH: waiting for the target mode's oscillators.
- WAIT: core parked, oscillators still running.
- STOP: all oscillators off.
- WAKE: waiting for the oscillators to come back after a stop.

The transitions are:
- RUN to SWITCH on a legal mode write.
- SWITCH to RUN when the target's oscillators are ready.
- RUN to WAIT on the WAIT strobe.
- WAIT to RUN on an interrupt.
- RUN to STOP on a stop request.
- STOP to WAKE on an interrupt.
- WAKE to RUN when the current mode's oscillators are ready.

Top module: `cpu_clk_pmc`

## Requirements
- R1: A synchronous reset, active high, leaves the block in RUN in main-clock mode. After it, `clk_sel`=0, `div_code`=01000b, `osc_en`=0001b, `cpu_clk_en`=1 and `req_err`=0.
- R2: The mode codes written on `mode_wdata` map to source and oscillators as follows. The `osc_en` bits are bit0 main, bit1 PLL, bit2 sub, bit3 on-chip. The `clk_sel` values are 0 main, 1 PLL, 2 sub, 3 on-chip. In RUN each mode shows:

  | Code | Mode | `clk_sel` | `osc_en` |
  |---|---|---|---|
  | 0 | main | 0 | 0001 |
  | 1 | PLL | 1 | 0011 |
  | 2 | low-speed | 2 | 0101 |
  | 3 | low-power | 2 | 0100 |
  | 4 | on-chip | 3 | 1001 |
  | 5 | on-chip low-power | 3 | 1000 |

- R3: A legal mode change goes through SWITCH. While in SWITCH, `clk_sel` keeps the old source and `osc_en` is the union of the old and new modes' enables. The new mode takes effect on the first edge at which every oscillator the new mode needs has its `osc_rdy` bit high.
- R4: From a mode other than main, only main or the mode with the same source (2↔3, 4↔5) may be requested. Codes 6 and 7 are never legal. A refused write raises `req_err` for exactly one cycle and leaves the mode and state unchanged.
- R5: A request from mode 4 or 5 to mode 0 is accepted only when `div_code` equals 01000b. Otherwise it is refused as in R4.
- R6: A `div_wr` loads `div_wdata` into `div_code` on the next edge, in any state.
- R7: In RUN, `wait_stb` enters WAIT, where `cpu_clk_en`=0 and `osc_en` and `clk_sel` keep their RUN values. An `irq` in WAIT returns to RUN in the same mode.
- R8: In RUN, `stop_req` enters STOP, where `osc_en`=0 and `cpu_clk_en`=0. An `irq` moves to WAKE, which re-enables the current mode's oscillators with `cpu_clk_en`=0. WAKE returns to RUN when those oscillators are all ready.
- R9: An `irq` in the same cycle as `wait_stb` or `stop_req` cancels them: the block stays in RUN.
- R10: A mode write outside RUN is refused with a one-cycle `req_err`. A mode write in the same cycle as an accepted `wait_stb` or `stop_req` is dropped without error.
- R11: Writing the code of the current mode is accepted without error and without any state change. The block stays in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 3 | Requested mode code |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | DIV_W | Divider code to load |
| wait_stb | input | 1 | WAIT instruction strobe |
| stop_req | input | 1 | Stop control bit set |
| irq | input | 1 | Interrupt request |
| osc_rdy | input | 4 | Oscillator stable flags (main, PLL, sub, on-chip) |
| clk_sel | output | 2 | Active CPU clock source |
| div_code | output | DIV_W | Current main-clock divider code |
| osc_en | output | 4 | Oscillator enables (main, PLL, sub, on-chip) |
| cpu_clk_en | output | 1 | CPU clock running |
| req_err | output | 1 | One-cycle pulse for a refused mode write |

## Verification
Three pairs of functions can fall in the same cycle:
- An interrupt and a WAIT strobe or stop request.
- A mode write and an accepted WAIT strobe.
- A refused mode write and a switch that completes on the same edge.

The bench provokes each pair by driving both inputs on one edge. It judges the result from `cpu_clk_en`, `req_err`, `clk_sel` and `osc_en` on the following cycles. A sweep covers every start mode against every written code and both a safe and an unsafe divider code. Its expected legality and outputs are worked out in the bench from the mode table.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    localparam int OSC_N  = 4;
    localparam int SRC_W  = 2;
    localparam int MODE_W = 3;

    typedef enum logic [2:0] {
        M_MAIN    = 3'd0,
        M_PLL     = 3'd1,
        M_SUB     = 3'd2,
        M_SUBLP   = 3'd3,
        M_ONCH    = 3'd4,
        M_ONCHLP  = 3'd5
    } mode_e;

    typedef enum logic [2:0] {
        S_RUN,
        S_SWITCH,
        S_WAIT,
        S_STOP,
        S_WAKE
    } pstate_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_MAIN = 2'd0,
        SRC_PLL  = 2'd1,
        SRC_SUB  = 2'd2,
        SRC_ONCH = 2'd3
    } src_e;

    localparam int MODE_LAST = 5;

    function automatic src_e src_of(mode_e m);
        src_e s;
        unique case (m)
            M_MAIN:           s = SRC_MAIN;
            M_PLL:            s = SRC_PLL;
            M_SUB, M_SUBLP:   s = SRC_SUB;
            M_ONCH, M_ONCHLP: s = SRC_ONCH;
            default:          s = SRC_MAIN;
        endcase
        return s;
    endfunction

    // bit0 main, bit1 PLL, bit2 sub, bit3 on-chip
    function automatic logic [OSC_N-1:0] osc_need(mode_e m);
        logic [OSC_N-1:0] v;
        unique case (m)
            M_MAIN:   v = 4'b0001;
            M_PLL:    v = 4'b0011;
            M_SUB:    v = 4'b0101;
            M_SUBLP:  v = 4'b0100;
            M_ONCH:   v = 4'b1001;
            M_ONCHLP: v = 4'b1000;
            default:  v = 4'b0001;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pmc_legal.sv
module pmc_legal
    import pmc_pkg::*;
#(
    parameter int                DIV_W    = 5,
    parameter logic [DIV_W-1:0]  DIV_SAFE = 5'b01000
) (
    input  mode_e                cur,
    input  logic [MODE_W-1:0]    req,
    input  logic [DIV_W-1:0]     div,
    output logic                 legal,
    output logic                 same
);

    logic  code_ok;
    mode_e req_m;
    logic  from_onch;

    always_comb begin
        code_ok   = (int'(req) <= MODE_LAST);
        req_m     = mode_e'(req);
        from_onch = (cur == M_ONCH) || (cur == M_ONCHLP);
        same      = code_ok && (req_m == cur);
        if (!code_ok) begin
            legal = 1'b0;
        end else if (same) begin
            legal = 1'b1;
        end else if (cur == M_MAIN) begin
            legal = 1'b1;
        end else if (req_m == M_MAIN) begin
            legal = !from_onch || (div == DIV_SAFE);
        end else begin
            legal = (src_of(req_m) == src_of(cur));
        end
    end

endmodule

// File: rtl/pmc_osc_ctl.sv
module pmc_osc_ctl
    import pmc_pkg::*;
(
    input  pstate_e           st,
    input  mode_e             cur,
    input  mode_e             tgt,
    output logic [OSC_N-1:0]  en
);

    logic [OSC_N-1:0] need_cur;
    logic [OSC_N-1:0] need_tgt;
    logic             halted;
    logic             moving;

    always_comb begin
        need_cur = osc_need(cur);
        need_tgt = osc_need(tgt);
        halted   = (st == S_STOP);
        moving   = (st == S_SWITCH);
    end

    for (genvar i = 0; i < OSC_N; i++) begin : g_osc
        assign en[i] = !halted && (need_cur[i] || (moving && need_tgt[i]));
    end

endmodule

// File: rtl/cpu_clk_pmc.sv
module cpu_clk_pmc
    import pmc_pkg::*;
#(
    parameter int                DIV_W    = 5,
    parameter logic [DIV_W-1:0]  DIV_SAFE = 5'b01000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 mode_wr,
    input  logic [MODE_W-1:0]    mode_wdata,
    input  logic                 div_wr,
    input  logic [DIV_W-1:0]     div_wdata,
    input  logic                 wait_stb,
    input  logic                 stop_req,
    input  logic                 irq,
    input  logic [OSC_N-1:0]     osc_rdy,
    output logic [SRC_W-1:0]     clk_sel,
    output logic [DIV_W-1:0]     div_code,
    output logic [OSC_N-1:0]     osc_en,
    output logic                 cpu_clk_en,
    output logic                 req_err
);

    pstate_e          st_q,  st_d;
    mode_e            cur_q, cur_d;
    mode_e            tgt_q, tgt_d;
    logic [DIV_W-1:0] div_q;
    logic             err_q, err_d;

    logic             req_legal;
    logic             req_same;
    logic             tgt_ready;
    logic             cur_ready;
    logic [OSC_N-1:0] osc_en_w;

    pmc_legal #(
        .DIV_W    (DIV_W),
        .DIV_SAFE (DIV_SAFE)
    ) i_legal (
        .cur   (cur_q),
        .req   (mode_wdata),
        .div   (div_q),
        .legal (req_legal),
        .same  (req_same)
    );

    pmc_osc_ctl i_osc (
        .st  (st_q),
        .cur (cur_q),
        .tgt (tgt_q),
        .en  (osc_en_w)
    );

    always_comb begin
        tgt_ready = ((osc_need(tgt_q) & ~osc_rdy) == '0);
        cur_ready = ((osc_need(cur_q) & ~osc_rdy) == '0);
    end

    // next-state decision
    always_comb begin
        st_d  = st_q;
        cur_d = cur_q;
        tgt_d = tgt_q;
        err_d = 1'b0;
        unique case (st_q)
            S_RUN: begin
                if (!irq && stop_req) begin
                    st_d = S_STOP;
                end else if (!irq && wait_stb) begin
                    st_d = S_WAIT;
                end else if (mode_wr) begin
                    if (!req_legal) begin
                        err_d = 1'b1;
                    end else if (!req_same) begin
                        tgt_d = mode_e'(mode_wdata);
                        st_d  = S_SWITCH;
                    end
                end
            end
            S_SWITCH: begin
                err_d = mode_wr;
                if (tgt_ready) begin
                    cur_d = tgt_q;
                    st_d  = S_RUN;
                end
            end
            S_WAIT: begin
                err_d = mode_wr;
                if (irq) begin
                    st_d = S_RUN;
                end
            end
            S_STOP: begin
                err_d = mode_wr;
                if (irq) begin
                    st_d = S_WAKE;
                end
            end
            S_WAKE: begin
                err_d = mode_wr;
                if (cur_ready) begin
                    st_d = S_RUN;
                end
            end
            default: begin
                st_d = S_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_RUN;
            cur_q <= M_MAIN;
            tgt_q <= M_MAIN;
            div_q <= DIV_SAFE;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
            tgt_q <= tgt_d;
            err_q <= err_d;
            if (div_wr) begin
                div_q <= div_wdata;
            end
        end
    end

    // outputs
    always_comb begin
        clk_sel    = src_of(cur_q);
        div_code   = div_q;
        osc_en     = osc_en_w;
        cpu_clk_en = (st_q == S_RUN) || (st_q == S_SWITCH);
        req_err    = err_q;
    end

    AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_STOP) |-> (osc_en == '0)); // R8

    AST_WAKE_ENABLES: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_WAKE) |-> (osc_en == osc_need(cur_q) && !cpu_clk_en)); // R8

    AST_SWITCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_SWITCH && !tgt_ready) |=> (st_q == S_SWITCH && $stable(cur_q))); // R3

    AST_HUB_PATH: assert property (@(posedge clk) disable iff (rst)
        (cur_q != $past(cur_q)) |-> ($past(cur_q) == M_MAIN || cur_q == M_MAIN
                                     || src_of(cur_q) == src_of($past(cur_q)))); // R4

    AST_REFUSE_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        (err_q && $past(st_q) == S_RUN) |-> (st_q == S_RUN && cur_q == $past(cur_q))); // R4

    AST_IRQ_FIRST: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_RUN && irq) |=> (st_q != S_WAIT && st_q != S_STOP)); // R9

    AST_WAIT_RESUME: assert property (@(posedge clk) disable iff (rst)
        (st_q == S_WAIT && irq) |=> (st_q == S_RUN && $stable(cur_q))); // R7

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (rst)
        (err_q && !$past(mode_wr, 1)) |-> 1'b0); // R10

endmodule

// File: tb/test_cpu_clk_pmc.sv
module test_cpu_clk_pmc;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_wdata = '0;
    logic       div_wr = 1'b0;
    logic [4:0] div_wdata = '0;
    logic       wait_stb = 1'b0;
    logic       stop_req = 1'b0;
    logic       irq = 1'b0;
    logic [3:0] osc_rdy = 4'b1111;
    logic [1:0] clk_sel;
    logic [4:0] div_code;
    logic [3:0] osc_en;
    logic       cpu_clk_en;
    logic       req_err;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_clk_pmc i_cpu_clk_pmc (
        .clk        (clk),
        .rst        (rst),
        .mode_wr    (mode_wr),
        .mode_wdata (mode_wdata),
        .div_wr     (div_wr),
        .div_wdata  (div_wdata),
        .wait_stb   (wait_stb),
        .stop_req   (stop_req),
        .irq        (irq),
        .osc_rdy    (osc_rdy),
        .clk_sel    (clk_sel),
        .div_code   (div_code),
        .osc_en     (osc_en),
        .cpu_clk_en (cpu_clk_en),
        .req_err    (req_err)
    );

    function automatic int exp_sel(int m);
        if (m == 0) return 0;
        if (m == 1) return 1;
        if (m <= 3) return 2;
        return 3;
    endfunction

    function automatic logic [3:0] exp_osc(int m);
        case (m)
            0: return 4'b0001;
            1: return 4'b0011;
            2: return 4'b0101;
            3: return 4'b0100;
            4: return 4'b1001;
            default: return 4'b1000;
        endcase
    endfunction

    function automatic bit exp_legal(int f, int t, int d);
        if (t > 5) return 0;
        if (t == f) return 1;
        if (f == 0) return 1;
        if (t == 0) return !(f == 4 || f == 5) || d == 8;
        return exp_sel(t) == exp_sel(f);
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; mode_wr = 0; div_wr = 0; wait_stb = 0; stop_req = 0; irq = 0;
        osc_rdy = 4'b1111;
        tick(2);
        rst = 1'b0;
    endtask

    task automatic wr_mode(int m);
        mode_wr = 1'b1; mode_wdata = 3'(m);
        @(negedge clk);
        mode_wr = 1'b0;
    endtask

    task automatic wr_div(int v);
        div_wr = 1'b1; div_wdata = 5'(v);
        @(negedge clk);
        div_wr = 1'b0;
    endtask

    task automatic pulse_irq();
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 clk_sel", clk_sel, 0);
        chk("R1 div_code", div_code, 8);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 cpu_clk_en", cpu_clk_en, 1);
        chk("R1 req_err", req_err, 0);

        // R6 every divider code, loaded in RUN
        for (int v = 0; v < 32; v++) begin
            wr_div(v);
            chk("R6 div load", div_code, v);
        end

        // R2 R4 R5 sweep: start mode x written code x divider
        for (int f = 0; f < 6; f++) begin
            for (int t = 0; t < 8; t++) begin
                for (int ds = 0; ds < 2; ds++) begin
                    int  d;
                    bit  ok;
                    int  e;
                    d = (ds == 0) ? 8 : 3;
                    do_reset();
                    wr_div(d);
                    if (f != 0) begin
                        wr_mode(f);
                        tick(1);
                    end
                    chk("R2 start sel", clk_sel, exp_sel(f));
                    ok = exp_legal(f, t, d);
                    wr_mode(t);
                    if ((f == 4 || f == 5) && t == 0)
                        chk("R5 err", req_err, !ok);
                    else
                        chk("R4 err", req_err, !ok);
                    tick(1);
                    e = ok ? t : f;
                    chk("R4 err one cycle", req_err, 0);
                    chk("R2 sel", clk_sel, exp_sel(e));
                    chk("R2 osc_en", osc_en, exp_osc(e));
                end
            end
        end

        // R3 switch waits on PLL ready; R10 write during switch
        do_reset();
        osc_rdy = 4'b1101;
        wr_mode(1);
        tick(3);
        chk("R3 sel held", clk_sel, 0);
        chk("R3 union osc_en", osc_en, 4'b0011);
        chk("R3 cpu runs", cpu_clk_en, 1);
        wr_mode(0);
        chk("R10 err in switch", req_err, 1);
        osc_rdy = 4'b1111;
        tick(1);
        chk("R3 switched sel", clk_sel, 1);
        chk("R3 switched osc", osc_en, 4'b0011);

        // R3 low-power to low-speed waits on main ready
        do_reset();
        wr_mode(2); tick(1);
        wr_mode(3); tick(1);
        chk("R2 lowpower osc", osc_en, 4'b0100);
        osc_rdy = 4'b1110;
        wr_mode(2); tick(2);
        chk("R3 wait main osc", osc_en, 4'b0101);
        chk("R3 still lowpower", exp_sel(3), clk_sel);
        wr_mode(0);
        chk("R10 err while switching", req_err, 1);
        osc_rdy = 4'b1111;
        tick(1);
        wr_mode(0); tick(1);
        chk("R3 reach main", clk_sel, 0);

        // R7 wait and resume
        do_reset();
        wr_mode(4); tick(1);
        wait_stb = 1'b1; @(negedge clk); wait_stb = 1'b0;
        chk("R7 wait cpu off", cpu_clk_en, 0);
        chk("R7 wait osc kept", osc_en, 4'b1001);
        chk("R7 wait sel kept", clk_sel, 3);
        wr_mode(0);
        chk("R10 err in wait", req_err, 1);
        wr_div(17);
        chk("R6 div in wait", div_code, 17);
        pulse_irq();
        chk("R7 resume cpu", cpu_clk_en, 1);
        chk("R7 resume sel", clk_sel, 3);

        // R9 irq beats wait and stop
        do_reset();
        wait_stb = 1'b1; irq = 1'b1; @(negedge clk); wait_stb = 1'b0; irq = 1'b0;
        chk("R9 irq vs wait", cpu_clk_en, 1);
        stop_req = 1'b1; irq = 1'b1; @(negedge clk); stop_req = 1'b0; irq = 1'b0;
        chk("R9 irq vs stop", cpu_clk_en, 1);
        chk("R9 osc kept", osc_en, 4'b0001);

        // R10 mode write together with wait is dropped
        do_reset();
        wait_stb = 1'b1; mode_wr = 1'b1; mode_wdata = 3'd1;
        @(negedge clk);
        wait_stb = 1'b0; mode_wr = 1'b0;
        chk("R10 dropped no err", req_err, 0);
        chk("R10 in wait", cpu_clk_en, 0);
        pulse_irq();
        tick(1);
        chk("R10 mode unchanged", clk_sel, 0);
        chk("R10 osc unchanged", osc_en, 4'b0001);

        // R11 same-mode write stays in RUN
        do_reset();
        wr_mode(0);
        chk("R11 no err", req_err, 0);
        wait_stb = 1'b1; @(negedge clk); wait_stb = 1'b0;
        chk("R11 still RUN", cpu_clk_en, 0);
        pulse_irq();

        // R8 stop and wake on PLL
        do_reset();
        wr_mode(1); tick(1);
        stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
        chk("R8 stop osc off", osc_en, 0);
        chk("R8 stop cpu off", cpu_clk_en, 0);
        tick(3);
        chk("R8 stop holds", osc_en, 0);
        osc_rdy = 4'b1101;
        pulse_irq();
        chk("R8 wake osc", osc_en, 4'b0011);
        chk("R8 wake cpu off", cpu_clk_en, 0);
        tick(2);
        chk("R8 wake waits", cpu_clk_en, 0);
        osc_rdy = 4'b1111;
        tick(1);
        chk("R8 running", cpu_clk_en, 1);
        chk("R8 sel kept", clk_sel, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule